// File: doc/BRIEF.md
# S/Q Maintenance Channel Buffer

This block sits between a line framer and a host controller. It holds the four-bit maintenance words that an S/T interface multiframe carries in its S and Q bit slots. Two downstream words (subchannels S1 and S2) are written by the host and sent out bit by bit in fixed frame positions of every multiframe. One upstream word (Q) is collected from the received Q bit slots and reported to the host as a byte message. The upper nibble of the byte is a message-type identifier and the lower nibble carries the data.

The framer gives one `frameStrobe` pulse per frame, together with the position of that frame inside the multiframe. The S1 bits occupy positions `S1_BASE`..`S1_BASE+3`, the S2 bits `S2_BASE`..`S2_BASE+3` and the Q bits `Q_BASE`..`Q_BASE+3`. In each group the most significant bit of the word comes first.

In transparent mode every received Q word is passed to the host once per multiframe. In change-driven mode a Q word is reported only when it differs from the word received before it. In both modes each S word is sent again in every multiframe until the host replaces it.

Top module: `sq_buffer`

## Requirements
- R1: During and directly after reset, all three cells hold zero, `txSBit` is 0, `hostOutValid` is 0 and `errSticky` is 0.
- R2: A host byte with `hostInValid` high and bits 7:4 equal to 0001 loads bits 3:0 into the S1 cell. Bits 7:4 equal to 0010 load the S2 cell. The other cells are left unchanged.
- R3: With `modeTransparent` low, the Q word is assembled from the `rxQBit` values sampled at the strobes for positions `Q_BASE`..`Q_BASE+3`, with the first bit as bit 3. One cycle after the strobe at `Q_BASE+3`, `hostOutValid` pulses with `hostOutByte` = {0001, word}, but only if the word differs from the previously received word. The previous word is zero after reset.
- R4: With `modeTransparent` high, the report in R3 is made in every multiframe, whether or not the word changed.
- R5: On a strobe at position `S1_BASE+k` (k = 0..3), `txSBit` takes bit 3-k of the S1 cell in the next cycle. Positions `S2_BASE+k` do the same with the S2 cell. `txSBit` keeps its value until the next strobe.
- R6: A written S word is sent again in every multiframe until the host writes a new value to that cell.
- R7: On a strobe at any position outside the S1 and S2 groups, `txSBit` is 0 in the next cycle.
- R8: A host byte whose bits 7:4 are neither 0001 nor 0010 changes no cell, and it sets `errSticky`. `errSticky` then stays set until reset.
- R9: Any change of `modeTransparent` clears the previous Q word to zero, so in change-driven mode the next non-zero word is reported again.
- R10: A host write and a strobe in the same cycle: the strobe transmits the cell value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| modeTransparent | input | 1 | 1 = transparent, 0 = change-driven |
| hostInValid | input | 1 | Host message strobe |
| hostInByte | input | 8 | Host message: identifier in 7:4, data in 3:0 |
| hostOutValid | output | 1 | Q report strobe |
| hostOutByte | output | 8 | Q report: identifier 0001 in 7:4, word in 3:0 |
| frameStrobe | input | 1 | One pulse per frame |
| framePos | input | $clog2(FRAMES) | Frame position in the multiframe |
| rxQBit | input | 1 | Received Q bit for the strobed frame |
| txSBit | output | 1 | S bit to send for the current frame |
| errSticky | output | 1 | Set by an unknown identifier |

## Verification
The bench uses the default parameters: 20 frames per multiframe, S1 at positions 0..3, S2 at 10..13 and Q at 0..3. This places the S1 and Q groups on the same frames, which tests receive and transmit at the same time. With one strobe every four cycles, a multiframe lasts 80 cycles, so dozens of multiframes fit into one run. That is enough for constant Q words (only one report in change-driven mode), a mode switch back and forth, and host writes that land on a strobe cycle.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int NIB  = 4;
  localparam int NIBW = $clog2(NIB);
  localparam int BYTEW = 2 * NIB;

  localparam logic [NIB-1:0] ID_S1 = 4'b0001;
  localparam logic [NIB-1:0] ID_S2 = 4'b0010;
  localparam logic [NIB-1:0] ID_Q  = 4'b0001;

  typedef enum logic [1:0] {TX_NONE = 2'd0, TX_S1 = 2'd1, TX_S2 = 2'd2} txSel_e;

  typedef struct packed {
    logic            wrS1;
    logic            wrS2;
    logic            badId;
    logic            capQ;
    logic            endQ;
    logic            loadTx;
    txSel_e          txSel;
    logic [NIBW-1:0] txIdx;
    logic            clearHist;
    logic            reportAll;
  } sqStrobe_t;
endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl
  import sq_pkg::*;
#(
  parameter int FRAMES  = 20,
  parameter int S1_BASE = 0,
  parameter int S2_BASE = 10,
  parameter int Q_BASE  = 0,
  localparam int POSW = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             modeTransparent,
  input  logic             hostInValid,
  input  logic [NIB-1:0]   hostId,
  input  logic             frameStrobe,
  input  logic [POSW-1:0]  framePos,
  output sqStrobe_t        st
);
  logic modePrev;

  always_ff @(posedge clk) begin
    if (!rst_n) modePrev <= 1'b0;
    else        modePrev <= modeTransparent;
  end

  always_comb begin
    int pos;
    int offS1;
    int offS2;
    int offQ;
    pos   = int'(framePos);
    offS1 = pos - S1_BASE;
    offS2 = pos - S2_BASE;
    offQ  = pos - Q_BASE;
    st = '0;
    st.reportAll = modeTransparent;
    st.clearHist = modeTransparent != modePrev;
    if (hostInValid) begin
      if (hostId == ID_S1)      st.wrS1  = 1'b1;
      else if (hostId == ID_S2) st.wrS2  = 1'b1;
      else                      st.badId = 1'b1;
    end
    if (frameStrobe) begin
      st.loadTx = 1'b1;
      if (offS1 >= 0 && offS1 < NIB) begin
        st.txSel = TX_S1;
        st.txIdx = NIBW'(NIB - 1 - offS1);
      end else if (offS2 >= 0 && offS2 < NIB) begin
        st.txSel = TX_S2;
        st.txIdx = NIBW'(NIB - 1 - offS2);
      end
      if (offQ >= 0 && offQ < NIB - 1) st.capQ = 1'b1;
      if (offQ == NIB - 1)             st.endQ = 1'b1;
    end
  end
endmodule

// File: rtl/sq_datapath.sv
module sq_datapath
  import sq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  sqStrobe_t        st,
  input  logic [NIB-1:0]   hostNibble,
  input  logic             rxQBit,
  output logic             txSBit,
  output logic             hostOutValid,
  output logic [BYTEW-1:0] hostOutByte,
  output logic             errSticky
);
  logic [NIB-1:0] s1Cell, s2Cell, qCell;
  logic [NIB-2:0] qShift;
  logic [NIB-1:0] newWord, histNow;

  assign newWord = {qShift, rxQBit};
  assign histNow = st.clearHist ? '0 : qCell;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1Cell       <= '0;
      s2Cell       <= '0;
      qCell        <= '0;
      qShift       <= '0;
      txSBit       <= 1'b0;
      hostOutValid <= 1'b0;
      hostOutByte  <= '0;
      errSticky    <= 1'b0;
    end else begin
      hostOutValid <= 1'b0;
      if (st.wrS1)  s1Cell    <= hostNibble;
      if (st.wrS2)  s2Cell    <= hostNibble;
      if (st.badId) errSticky <= 1'b1;
      if (st.loadTx) begin
        case (st.txSel)
          TX_S1:   txSBit <= s1Cell[st.txIdx];
          TX_S2:   txSBit <= s2Cell[st.txIdx];
          default: txSBit <= 1'b0;
        endcase
      end
      if (st.capQ) qShift <= {qShift[NIB-3:0], rxQBit};
      if (st.clearHist) qCell <= '0;
      if (st.endQ) begin
        qCell <= newWord;
        if (st.reportAll || newWord != histNow) begin
          hostOutValid <= 1'b1;
          hostOutByte  <= {ID_Q, newWord};
        end
      end
    end
  end
endmodule

// File: rtl/sq_buffer.sv
module sq_buffer
  import sq_pkg::*;
#(
  parameter int FRAMES  = 20,
  parameter int S1_BASE = 0,
  parameter int S2_BASE = 10,
  parameter int Q_BASE  = 0,
  localparam int POSW = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             modeTransparent,
  input  logic             hostInValid,
  input  logic [BYTEW-1:0] hostInByte,
  output logic             hostOutValid,
  output logic [BYTEW-1:0] hostOutByte,
  input  logic             frameStrobe,
  input  logic [POSW-1:0]  framePos,
  input  logic             rxQBit,
  output logic             txSBit,
  output logic             errSticky
);
  sqStrobe_t st;

  sq_ctrl #(
    .FRAMES(FRAMES), .S1_BASE(S1_BASE), .S2_BASE(S2_BASE), .Q_BASE(Q_BASE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .modeTransparent(modeTransparent),
    .hostInValid(hostInValid), .hostId(hostInByte[BYTEW-1:NIB]),
    .frameStrobe(frameStrobe), .framePos(framePos), .st(st)
  );

  sq_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .hostNibble(hostInByte[NIB-1:0]),
    .rxQBit(rxQBit), .txSBit(txSBit), .hostOutValid(hostOutValid),
    .hostOutByte(hostOutByte), .errSticky(errSticky)
  );
endmodule

// File: rtl/sq_buffer_chk.sv
module sq_buffer_chk #(
  parameter int FRAMES  = 20,
  parameter int S1_BASE = 0,
  parameter int S2_BASE = 10,
  parameter int Q_BASE  = 0,
  localparam int POSW = $clog2(FRAMES)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hostInValid,
  input logic [7:0]      hostInByte,
  input logic            hostOutValid,
  input logic [7:0]      hostOutByte,
  input logic            frameStrobe,
  input logic [POSW-1:0] framePos,
  input logic            txSBit,
  input logic            errSticky
);
  logic inS1, inS2, badMsg;
  assign inS1 = int'(framePos) >= S1_BASE && int'(framePos) < S1_BASE + 4;
  assign inS2 = int'(framePos) >= S2_BASE && int'(framePos) < S2_BASE + 4;
  assign badMsg = hostInValid && hostInByte[7:4] != 4'b0001 && hostInByte[7:4] != 4'b0010;

  // R8
  bad_id_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    badMsg |=> errSticky);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errSticky |=> errSticky);
  // R3
  report_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hostOutValid |-> ($past(frameStrobe) && int'($past(framePos)) == Q_BASE + 3));
  // R3
  report_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hostOutValid |-> hostOutByte[7:4] == 4'b0001);
  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frameStrobe |=> $stable(txSBit));
  // R7
  tx_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frameStrobe && !inS1 && !inS2) |=> !txSBit);
endmodule

bind sq_buffer sq_buffer_chk #(
  .FRAMES(FRAMES), .S1_BASE(S1_BASE), .S2_BASE(S2_BASE), .Q_BASE(Q_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hostInValid(hostInValid), .hostInByte(hostInByte),
  .hostOutValid(hostOutValid), .hostOutByte(hostOutByte), .frameStrobe(frameStrobe),
  .framePos(framePos), .txSBit(txSBit), .errSticky(errSticky)
);

// File: tb/sim_sq_buffer.sv
module sim_sq_buffer;
  localparam int FRAMES = 20, S1B = 0, S2B = 10, QB = 0;
  localparam int POSW = $clog2(FRAMES);
  localparam int MF = FRAMES * 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, modeT = 1'b0, hostInValid = 1'b0, frameStrobe = 1'b0, rxQBit = 1'b0;
  logic [7:0] hostInByte = '0;
  logic [POSW-1:0] framePos = '0;
  logic hostOutValid, txSBit, errSticky;
  logic [7:0] hostOutByte;

  sq_buffer #(.FRAMES(FRAMES), .S1_BASE(S1B), .S2_BASE(S2B), .Q_BASE(QB)) u0 (
    .clk(clk), .rst_n(rst_n), .modeTransparent(modeT), .hostInValid(hostInValid),
    .hostInByte(hostInByte), .hostOutValid(hostOutValid), .hostOutByte(hostOutByte),
    .frameStrobe(frameStrobe), .framePos(framePos), .rxQBit(rxQBit),
    .txSBit(txSBit), .errSticky(errSticky)
  );

  int tests = 0, fails = 0, cyc = 0, rpt = 0;
  bit done = 0, live = 0;
  logic [3:0] qWord = 4'h5;

  // behavioural reference model
  logic [3:0] mS1, mS2, mHist, mAcc;
  logic mTx, mValid, mErr, mPrev;
  logic [7:0] mByte;

  always @(posedge clk) begin
    if (!rst_n) begin
      mS1 = 0; mS2 = 0; mHist = 0; mAcc = 0;
      mTx = 0; mValid = 0; mErr = 0; mPrev = 0; mByte = 0;
    end else begin
      int p;
      mValid = 0;
      if (modeT != mPrev) mHist = 0;
      mPrev = modeT;
      if (frameStrobe) begin
        p = int'(framePos);
        if (p >= S1B && p < S1B + 4)      mTx = mS1[3 - (p - S1B)];
        else if (p >= S2B && p < S2B + 4) mTx = mS2[3 - (p - S2B)];
        else                              mTx = 0;
        if (p >= QB && p < QB + 4) begin
          mAcc = {mAcc[2:0], rxQBit};
          if (p == QB + 3) begin
            if (modeT || mAcc != mHist) begin
              mValid = 1; mByte = {4'b0001, mAcc};
            end
            mHist = mAcc;
          end
        end
      end
      if (hostInValid) begin
        if (hostInByte[7:4] == 4'b0001)      mS1 = hostInByte[3:0];
        else if (hostInByte[7:4] == 4'b0010) mS2 = hostInByte[3:0];
        else                                 mErr = 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic compare();
    check(txSBit === mTx, "R5 R6 R7 R10 R2 txSBit", int'(txSBit), int'(mTx));
    check(hostOutValid === mValid, "R3 R4 R9 hostOutValid", int'(hostOutValid), int'(mValid));
    if (mValid) check(hostOutByte === mByte, "R3 hostOutByte", int'(hostOutByte), int'(mByte));
    check(errSticky === mErr, "R8 errSticky", int'(errSticky), int'(mErr));
    if (hostOutValid) rpt++;
  endtask

  task automatic step(input logic hv, input logic [7:0] hb);
    int pos;
    @(negedge clk);
    if (live) compare();
    pos = (cyc / 4) % FRAMES;
    frameStrobe = (cyc % 4) == 0;
    framePos = POSW'(pos);
    rxQBit = (pos >= QB && pos < QB + 4) ? qWord[3 - (pos - QB)] : 1'($urandom);
    hostInValid = hv;
    hostInByte = hb;
    cyc++;
  endtask

  task automatic runMf(input int n, input bit randQ, input bit randHost, input bit randMode);
    for (int i = 0; i < n * MF; i++) begin
      logic hv;
      logic [7:0] hb;
      if (cyc % MF == 0) begin
        if (randQ) qWord = 4'($urandom);
        if (randMode && ($urandom % 3 == 0)) modeT = ~modeT;
      end
      hv = randHost && ($urandom % 12 == 0);
      hb = {($urandom % 2 == 0) ? 4'b0001 : 4'b0010, 4'($urandom)};
      step(hv, hb);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(txSBit === 0 && hostOutValid === 0 && errSticky === 0, "R1 reset outputs",
          {txSBit, hostOutValid, errSticky}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(txSBit === 0 && hostOutValid === 0 && errSticky === 0, "R1 after reset",
          {txSBit, hostOutValid, errSticky}, 0);
    live = 1;
    cyc = 0;
    // R3: constant non-zero word in change-driven mode is reported once
    modeT = 0; qWord = 4'h5; rpt = 0;
    runMf(5, 0, 0, 0);
    check(rpt == 1, "R3 reports for constant word", rpt, 1);
    // R4: transparent mode reports every multiframe
    modeT = 1; rpt = 0;
    runMf(5, 0, 0, 0);
    check(rpt == 5, "R4 reports in transparent mode", rpt, 5);
    // R9: return to change-driven mode clears history
    modeT = 0; rpt = 0;
    runMf(3, 0, 0, 0);
    check(rpt == 1, "R9 report after mode change", rpt, 1);
    // R2 R6: write both S cells, then repeat for several multiframes
    step(1'b1, 8'h1A);
    step(1'b1, 8'h23);
    runMf(3, 1, 0, 0);
    // R8: unknown identifier
    step(1'b1, 8'h7F);
    step(1'b0, 8'h00);
    check(errSticky === 1, "R8 sticky after bad id", int'(errSticky), 1);
    runMf(2, 1, 0, 0);
    check(errSticky === 1, "R8 flag held", int'(errSticky), 1);
    // R10 and mixed traffic: random writes land on strobe cycles too
    runMf(30, 1, 1, 1);
    step(1'b0, 8'h00);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule